// File: doc/BRIEF.md
# Serial CRC-4 Generator and Checker

This block computes a four-bit cyclic check over a serial bit stream, one bit per clock. A single division register serves both directions. A mode input picks the direction, and the block samples it on the first bit of each frame. The generator polynomial is x^4 + x + 1. The first bit of a frame is the highest-order coefficient of the message polynomial.

In transmit mode the block forwards each accepted message bit to its serial output and folds that bit into the register. After the frame's last bit, a small controller pushes four zero bits through the register to form the signature. It then sends the four signature bits immediately after the last message bit, with no gap. To make this possible, message bits go through a short delay line that matches the length of the flush. In receive mode the block takes in the message followed by its four-bit signature and produces no serial output. One cycle after the frame's last bit, it raises a result flag, and a second output reports whether the remainder is zero.

Top module: `crc4_serial_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_last`, `chk_valid` and `crc_ok` are all low.
- R2: In transmit mode, every accepted message bit appears on `out_bit` with `out_valid` high exactly CRC_W+1 (5) cycles after the cycle in which it was accepted, in order. Idle input cycles inside a frame appear as idle output cycles.
- R3: In transmit mode, the four signature bits come out in the four cycles right after the last message bit, most significant first. Together they equal the remainder of M(x)·x^4 divided by x^4 + x + 1.
- R4: `out_last` is high only together with the final signature bit, and only for one cycle.
- R5: A bit accepted with `in_sof` high clears the register before it is absorbed. A frame's signature therefore does not depend on any earlier frame.
- R6: In receive mode, `chk_valid` rises in the cycle after the bit marked `in_eof`. `crc_ok` is 1 exactly when message plus signature leave a zero remainder. `out_valid` stays low throughout the frame.
- R7: `chk_valid` and `crc_ok` hold their values until the next accepted start-of-frame bit, and both are low in the cycle after it.
- R8: Input bits are ignored during the 2·CRC_W cycles of a transmit tail, including start-of-frame bits. Valid bits without `in_sof` outside a frame are also ignored.
- R9: A gap (`in_valid` low) inside a frame leaves the register unchanged, so the signature and the check result match a gap-free frame.
- R10: `tx_mode` is taken only on the start-of-frame bit. Changing it mid-frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1 = transmit (generate), 0 = receive (check); sampled with the start-of-frame bit |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Serial input bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| in_eof | input | 1 | Marks the last bit of a frame (last signature bit in receive mode) |
| out_valid | output | 1 | Output bit present this cycle |
| out_bit | output | 1 | Serial output: delayed message bits, then the signature |
| out_last | output | 1 | High with the final signature bit |
| chk_valid | output | 1 | Receive check result is available |
| crc_ok | output | 1 | Remainder of the checked frame is zero |

## Verification
The bench builds the block with its default parameters: CRC_W = 4 and the x^4 + x + 1 feedback taps. With these values the payload latency is five cycles and the transmit tail is eight cycles. That is short enough to cover single-bit frames, frames with gaps, frames sent back to back after a tail, and start-of-frame noise that falls exactly inside the tail. Expected signatures come from a polynomial long division written in the bench on whole integers. This is independent of the shift-register form used in the design. Receive frames are built from that division, and one frame is deliberately corrupted.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_SIG   = 2'd3
  } crc_state_e;
endpackage

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
  parameter int          W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] rem,
  output logic [W-1:0] rem_nxt
);
  logic [W-1:0] base;

  // Division step: shift in one coefficient, reduce the overflowing x^W term.
  always_comb begin
    base    = clr ? '0 : rem;
    rem_nxt = {base[W-2:0], din} ^ (base[W-1] ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst)     rem <= '0;
    else if (en) rem <= rem_nxt;
  end

  // R5: a start-of-frame step leaves only the incoming bit in the register
  p_clear_on_sof_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && en) |=> (rem[W-1:1] == '0));
endmodule

// File: rtl/crc_delay_line.sv
module crc_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_v,
  input  logic in_b,
  output logic out_v,
  output logic out_b
);
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] b_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= in_v;
        b_q <= in_b;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[DEPTH-2:0], in_v};
        b_q <= {b_q[DEPTH-2:0], in_b};
      end
    end
  endgenerate

  assign out_v = v_q[DEPTH-1];
  assign out_b = b_q[DEPTH-1];
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc4_pkg::*;
#(
  parameter int W  = 4,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          tx_mode,
  output logic          take,
  output logic          sof_ok,
  output logic          mode_eff,
  output logic          flush,
  output logic          rx_done,
  output logic          sig_active,
  output logic [CW-1:0] sig_idx
);
  crc_state_e   state;
  logic [CW-1:0] cnt;
  logic          tx_q;
  logic          open_state;

  always_comb begin
    open_state = (state == ST_IDLE) || (state == ST_RUN);
    sof_ok     = in_valid && in_sof && open_state;
    take       = sof_ok || (in_valid && (state == ST_RUN));
    mode_eff   = sof_ok ? tx_mode : tx_q;
    flush      = (state == ST_FLUSH);
    rx_done    = take && in_eof && !mode_eff;
    sig_active = (state == ST_SIG);
    sig_idx    = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tx_q  <= 1'b0;
    end else begin
      if (sof_ok) tx_q <= tx_mode;
      case (state)
        ST_IDLE, ST_RUN: begin
          cnt <= '0;
          if (take && in_eof) state <= mode_eff ? ST_FLUSH : ST_IDLE;
          else if (sof_ok)    state <= ST_RUN;
        end
        ST_FLUSH: begin
          if (cnt == CW'(W-1)) begin
            cnt   <= '0;
            state <= ST_SIG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(W-1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R8: nothing is accepted while the tail is running
  p_no_take_in_tail_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH || state == ST_SIG) |-> !take);

  // R10: the frame direction stays fixed between start and end of frame
  p_mode_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !sof_ok) |=> $stable(tx_q));
endmodule

// File: rtl/crc4_serial_unit.sv
module crc4_serial_unit #(
  parameter int             CRC_W    = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 4'b0011,
  localparam int            CW       = (CRC_W > 1) ? $clog2(CRC_W) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_sof,
  input  logic in_eof,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  output logic chk_valid,
  output logic crc_ok
);
  logic              take, sof_ok, mode_eff, flush, rx_done, sig_active;
  logic [CW-1:0]     sig_idx;
  logic [CW-1:0]     sel;
  logic [CRC_W-1:0]  rem, rem_nxt;
  logic              dl_v, dl_b;

  crc_frame_ctrl #(.W(CRC_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .tx_mode(tx_mode),
    .take(take), .sof_ok(sof_ok), .mode_eff(mode_eff), .flush(flush),
    .rx_done(rx_done), .sig_active(sig_active), .sig_idx(sig_idx)
  );

  crc_shift_core #(.W(CRC_W), .POLY(CRC_POLY)) u_core (
    .clk(clk), .rst(rst),
    .clr(sof_ok), .en(take || flush), .din(take & in_bit),
    .rem(rem), .rem_nxt(rem_nxt)
  );

  crc_delay_line #(.DEPTH(CRC_W)) u_delay (
    .clk(clk), .rst(rst),
    .in_v(take && mode_eff), .in_b(in_bit),
    .out_v(dl_v), .out_b(dl_b)
  );

  assign sel = CW'(CRC_W-1) - sig_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
      chk_valid <= 1'b0;
      crc_ok    <= 1'b0;
    end else begin
      if (sig_active) begin
        out_valid <= 1'b1;
        out_bit   <= rem[sel];
        out_last  <= (sig_idx == CW'(CRC_W-1));
      end else begin
        out_valid <= dl_v;
        out_bit   <= dl_b;
        out_last  <= 1'b0;
      end
      if (rx_done) begin
        chk_valid <= 1'b1;
        crc_ok    <= (rem_nxt == '0);
      end else if (sof_ok) begin
        chk_valid <= 1'b0;
        crc_ok    <= 1'b0;
      end
    end
  end

  // R1: outputs are quiet on the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_last && !chk_valid && !crc_ok));

  // R3: while the signature is being sent the output stream has no hole
  p_sig_contiguous_r3: assert property (@(posedge clk) disable iff (rst)
    sig_active |-> out_valid);

  // R4: the last marker rides a valid bit and lasts one cycle
  p_last_valid_r4: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  p_last_single_r4: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_last);

  // R7: the receive result holds until a new frame starts or a new result lands
  p_chk_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !sof_ok && !rx_done) |=> (chk_valid && $stable(crc_ok)));
endmodule

// File: tb/crc4_serial_unit_bench.sv
`timescale 1ns/1ps
module crc4_serial_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_mode = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic out_valid, out_bit, out_last, chk_valid, crc_ok;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int cap_n = 0;
  int cap_c [64];
  bit cap_b [64];
  bit cap_l [64];
  int in_c [64];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crc4_serial_unit u_crc4_serial_unit (
    .clk(clk), .rst(rst), .tx_mode(tx_mode),
    .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .chk_valid(chk_valid), .crc_ok(crc_ok)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < 64) begin
      cap_c[cap_n] = cyc;
      cap_b[cap_n] = out_bit;
      cap_l[cap_n] = out_last;
      cap_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] rem4(input logic [31:0] msg, input int len);
    logic [63:0] v;
    v = {32'b0, msg} << 4;
    for (int i = len + 3; i >= 4; i--)
      if (v[i]) v = v ^ (64'h13 << (i - 4));
    return v[3:0];
  endfunction

  task automatic idle_cycle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bit = 1'b0;
  endtask

  // Drives one frame, MSB of bits first; records the cycle of each bit.
  task automatic drive_frame(input bit txm, input logic [31:0] bits, input int n,
                             input logic [31:0] gaps, input bit flip, input bit chk_clr,
                             output int last_cyc);
    tx_mode = txm;
    for (int i = 0; i < n; i++) begin
      if (gaps[i] && i > 0) idle_cycle();
      @(posedge clk); #1;
      in_valid = 1'b1; in_bit = bits[n-1-i];
      in_sof = (i == 0); in_eof = (i == n - 1);
      if (flip && i == 1) tx_mode = ~txm;
      in_c[i] = cyc;
      if (chk_clr && i == 1) begin
        @(negedge clk);
        check("R7 cleared by sof", int'(chk_valid), 0);
      end
    end
    last_cyc = cyc;
  endtask

  task automatic run_tx(input string tag, input logic [31:0] msg, input int n,
                        input logic [31:0] gaps, input bit noise, input bit flip);
    int e, tbad, pbad, sbad, lbad;
    logic [3:0] sg;
    cap_n = 0;
    sg = rem4(msg, n);
    drive_frame(1'b1, msg, n, gaps, flip, 1'b0, e);
    if (noise) begin
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); #1;
        in_valid = 1'b1; in_sof = 1'b1; in_eof = k[0]; in_bit = k[1];
      end
    end
    idle_cycle();
    tx_mode = 1'b0;
    repeat (14) @(posedge clk);
    @(negedge clk);
    tbad = 0; pbad = 0; sbad = 0; lbad = 0;
    check({tag, " R2/R8 output bit count"}, cap_n, n + 4);
    if (cap_n == n + 4) begin
      for (int i = 0; i < n; i++) begin
        if (cap_c[i] != in_c[i] + 5) tbad++;
        if (cap_b[i] != msg[n-1-i]) pbad++;
      end
      for (int k = 0; k < 4; k++) begin
        if (cap_c[n+k] != e + 6 + k) tbad++;
        if (cap_b[n+k] != sg[3-k]) sbad++;
      end
      for (int i = 0; i < n + 4; i++)
        if (cap_l[i] != (i == n + 3)) lbad++;
    end
    check({tag, " R2/R9 timing mismatches"}, tbad, 0);
    check({tag, " R2 payload mismatches"}, pbad, 0);
    check({tag, " R3/R5 signature mismatches"}, sbad, 0);
    check({tag, " R4 last-marker mismatches"}, lbad, 0);
  endtask

  task automatic run_rx(input string tag, input logic [31:0] msg, input int n,
                        input logic [3:0] flipmask, input logic [31:0] gaps,
                        input bit flip, input bit chk_clr, input bit exp_ok);
    int e;
    logic [31:0] fr;
    cap_n = 0;
    fr = (msg << 4) | {28'b0, rem4(msg, n) ^ flipmask};
    drive_frame(1'b0, fr, n + 4, gaps, flip, chk_clr, e);
    idle_cycle();
    tx_mode = 1'b0;
    @(negedge clk);
    check({tag, " R6 chk_valid next cycle"}, int'(chk_valid), 1);
    check({tag, " R6 crc_ok"}, int'(crc_ok), int'(exp_ok));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({tag, " R7 result held"}, int'({chk_valid, crc_ok}), int'({1'b1, exp_ok}));
    check({tag, " R6 no serial output in receive"}, cap_n, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", int'({out_valid, out_last, chk_valid, crc_ok}), 0);

    run_tx("tx8",  32'hA5,   8,  32'h0,   1'b0, 1'b0);
    run_tx("tx1",  32'h1,    1,  32'h0,   1'b0, 1'b0);
    // R5: back to back, register must restart from zero
    run_tx("tx13", 32'h1B3D, 13, 32'h124, 1'b1, 1'b0);
    // R10: mode flipped mid-frame
    run_tx("tx10", 32'h2F1,  10, 32'h0,   1'b0, 1'b1);

    run_rx("rxgood", 32'h2C9,  10, 4'h0, 32'h0,  1'b0, 1'b0, 1'b1);
    run_rx("rxbad",  32'h2C9,  10, 4'h4, 32'h0,  1'b0, 1'b1, 1'b0);
    // R9: gaps inside a receive frame
    run_rx("rxgap",  32'h7E15, 15, 4'h0, 32'h8A2, 1'b0, 1'b1, 1'b1);
    // R10: mode flipped to transmit mid receive frame
    run_rx("rxflip", 32'h5A,   7,  4'h0, 32'h0,  1'b1, 1'b0, 1'b1);

    // R8: valid bits without start-of-frame are ignored outside a frame
    cap_n = 0;
    tx_mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_bit = k[0]; in_eof = (k == 5);
    end
    idle_cycle();
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R8 stray bits produce no output", cap_n, 0);
    check("R8 stray bits leave result", int'({chk_valid, crc_ok}), 3);
    tx_mode = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule